// File: doc/BRIEF.md
# Phase-Programmable DDR Forwarded-Clock Generator

This block generates the forwarded clock that goes out beside a serial transmitter's data. It works at half-cycle resolution of the core clock. In every core cycle it delivers two levels: an early level for the first half of the cycle and a late level for the second half. A double-data-rate output stage can consume that pair directly. The clock period is programmed in whole core cycles and may be odd or even. The starting phase is programmed in half-cycle steps.

The generated clock is tied to the data stream. It moves forward only in cycles where the data shifter asserts its advance strobe, and it waits in place otherwise. The internal position is a half-cycle counter that runs modulo twice the period. It gains two half-cycles per advance. While the enable is low, the counter is held at the programmed starting phase, so the generator restarts from a known phase every time it is enabled. The surrounding control logic is expected to present a period of 1 and a phase of 0 after reset.

Top module: `ddrclk_gen`

## Requirements
- R1: During and immediately after reset the position is 0. The early level is therefore low, and the late level is high only when the effective period is 1 (the reset configuration is period 1, phase 0).
- R2: A period input of 0 acts as a period of 16 core cycles, which is 32 half-cycles.
- R3: Let P be the effective period and k the phase. Once enabled, with n advances taken so far, the early level equals ((k+2n) mod 2P) >= P and the late level equals ((k+2n+1) mod 2P) >= P. With P=1 the early and late levels always differ.
- R4: In a cycle where enable is high and the advance strobe is low, both levels stay unchanged in the following cycle.
- R5: With phase 0 the clock starts low. Its first rising edge comes P half-cycles of advance after the first data, which is P/2 advancing core cycles.
- R6: Each step of the phase moves the starting point forward by one half-cycle. For example, with P=2 and phase 1 the first cycle is early low and late high, and the next advancing cycle is early high and late low.
- R7: While enable is low the position is held at the programmed phase. When enable returns high, the output sequence restarts from that phase.
- R8: With phase 0 and an odd period, the first rising edge falls on the late slot of a core cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; low holds the generator at its starting phase |
| advance_i | input | 1 | Data shifter advance strobe; the clock moves one core cycle per strobe |
| period_i | input | 4 | Clock period in core cycles (0 means 16) |
| phase_i | input | 4 | Starting phase in half-cycles; must be below twice the period |
| fwd_clk_early_o | output | 1 | Clock level for the first half of the core cycle |
| fwd_clk_late_o | output | 1 | Clock level for the second half of the core cycle |

## Verification
Two events can fall in the same cycle: the modulo wrap of the position and a stalled advance. The bench provokes this with a pseudo-random advance pattern that drops about a quarter of the strobes, sweeping every legal period and phase pair so that stalls land on and beside the wrap point. Expected levels come from the closed-form formula in R3, indexed by the number of strobes actually taken. Enable is also dropped in a cycle with the strobe high, to show that the reload to the starting phase overrides the advance.

// File: rtl/ddrclk_pkg.sv
package ddrclk_pkg;

    // Two output slots per core cycle: first half and second half.
    typedef enum logic [0:0] {
        SLOT_EARLY = 1'b0,
        SLOT_LATE  = 1'b1
    } slot_e;

    localparam int unsigned SLOTS          = 2;
    // Half-cycles consumed by one advancing core cycle.
    localparam int unsigned STEP_PER_CYCLE = 2;

endpackage

// File: rtl/ddrclk_span.sv
// Maps the programmed period to the half-period and full period in half-cycles.
module ddrclk_span #(
    parameter int unsigned DIV_W = 4
) (
    input  logic [DIV_W-1:0]   div_i,
    output logic [DIV_W+1:0]   half_o,
    output logic [DIV_W+1:0]   span_o
);
    localparam int unsigned     HC_W = DIV_W + 2;
    localparam logic [HC_W-1:0] FULL = HC_W'(1) << DIV_W;

    always_comb begin
        if (div_i == '0) begin
            half_o = FULL;
        end else begin
            half_o = HC_W'(div_i);
        end
        span_o = half_o << 1;
    end

    // R2: the half-period never collapses to zero
    always_comb begin
        if (!$isunknown(div_i)) begin
            p_nonzero_half_r2: assert (half_o != '0 && half_o <= FULL);
        end
    end

endmodule

// File: rtl/ddrclk_pos.sv
// Half-cycle position counter: reload while idle, step by two per advance.
module ddrclk_pos #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             adv_i,
    input  logic [DIV_W-1:0] phase_i,
    input  logic [DIV_W+1:0] span_i,
    output logic [DIV_W+1:0] pos_o
);
    import ddrclk_pkg::*;

    localparam int unsigned HC_W = DIV_W + 2;

    typedef struct packed {
        logic [HC_W-1:0] pos;
    } pos_t;

    pos_t            st_d, st_q;
    logic [HC_W-1:0] step_d;

    always_comb begin
        st_d   = st_q;
        step_d = st_q.pos + HC_W'(STEP_PER_CYCLE);
        if (!en_i) begin
            st_d.pos = HC_W'(phase_i);
        end else if (adv_i) begin
            st_d.pos = (step_d >= span_i) ? (step_d - span_i) : step_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o = st_q.pos;

    // R7: idle cycles park the position at the programmed phase
    p_idle_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (st_q.pos == HC_W'($past(phase_i))));

    // R4: no strobe, no movement
    p_stall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !adv_i) |=> $stable(st_q.pos));

    // R3: an in-range position stays in range across an advance
    p_wrap_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && adv_i && st_q.pos < span_i) |=> (st_q.pos < $past(span_i)));

endmodule

// File: rtl/ddrclk_level.sv
// Turns the position into the two half-cycle clock levels.
module ddrclk_level #(
    parameter int unsigned DIV_W = 4
) (
    input  logic [DIV_W+1:0]                pos_i,
    input  logic [DIV_W+1:0]                half_i,
    input  logic [DIV_W+1:0]                span_i,
    output logic [ddrclk_pkg::SLOTS-1:0]    lvl_o
);
    import ddrclk_pkg::*;

    localparam int unsigned HC_W = DIV_W + 2;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [HC_W-1:0] probe;
        logic [HC_W-1:0] wrapped;
        always_comb begin
            probe    = pos_i + HC_W'(k);
            wrapped  = (probe >= span_i) ? (probe - span_i) : probe;
            lvl_o[k] = (wrapped >= half_i);
        end
    end

    // R3: a one-cycle period toggles every half-cycle
    always_comb begin
        if (!$isunknown({pos_i, half_i, span_i}) && half_i == HC_W'(1) && pos_i < span_i) begin
            p_fast_toggle_r3: assert (lvl_o[SLOT_EARLY] != lvl_o[SLOT_LATE]);
        end
    end

endmodule

// File: rtl/ddrclk_gen.sv
// Phase-programmable forwarded-clock generator, two levels per core cycle.
module ddrclk_gen #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             advance_i,
    input  logic [DIV_W-1:0] period_i,
    input  logic [DIV_W-1:0] phase_i,
    output logic             fwd_clk_early_o,
    output logic             fwd_clk_late_o
);
    import ddrclk_pkg::*;

    localparam int unsigned HC_W = DIV_W + 2;

    logic [HC_W-1:0]  half_w;
    logic [HC_W-1:0]  span_w;
    logic [HC_W-1:0]  pos_w;
    logic [SLOTS-1:0] lvl_w;

    ddrclk_span #(.DIV_W(DIV_W)) u_span (
        .div_i  (period_i),
        .half_o (half_w),
        .span_o (span_w)
    );

    ddrclk_pos #(.DIV_W(DIV_W)) u_pos (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (enable_i),
        .adv_i   (advance_i),
        .phase_i (phase_i),
        .span_i  (span_w),
        .pos_o   (pos_w)
    );

    ddrclk_level #(.DIV_W(DIV_W)) u_level (
        .pos_i  (pos_w),
        .half_i (half_w),
        .span_i (span_w),
        .lvl_o  (lvl_w)
    );

    assign fwd_clk_early_o = lvl_w[SLOT_EARLY];
    assign fwd_clk_late_o  = lvl_w[SLOT_LATE];

    // R5: an idle cycle with phase 0 leaves the clock low in the early slot
    p_start_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enable_i && phase_i == '0) |=> !fwd_clk_early_o);

endmodule

// File: tb/ddrclk_gen_bench.sv
module ddrclk_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       adv = 1'b0;
    logic [3:0] period = 4'd1;
    logic [3:0] phase = 4'd0;
    logic       early, late;

    int checks = 0;
    int errors = 0;
    logic [7:0] lfsr = 8'hA5;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddrclk_gen u_ddrclk_gen (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .enable_i        (en),
        .advance_i       (adv),
        .period_i        (period),
        .phase_i         (phase),
        .fwd_clk_early_o (early),
        .fwd_clk_late_o  (late)
    );

    function automatic bit lvl(int h, int p);
        return ((h % (2 * p)) >= p);
    endfunction

    task automatic chk(bit ge, bit gl, bit ee, bit el, string tag);
        checks++;
        if (ge !== ee || gl !== el) begin
            errors++;
            $display("FAIL %s: got early=%0b late=%0b expected early=%0b late=%0b (period=%0d phase=%0d)",
                     tag, ge, gl, ee, el, period, phase);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    endtask

    task automatic run_case(int d, int ph);
        int p;
        int n;
        bit stalled;
        string tag;
        p = (d == 0) ? 16 : d;
        en = 1'b0; adv = 1'b0;
        period = 4'(d); phase = 4'(ph);
        @(posedge clk); @(negedge clk);
        en = 1'b1;
        n = 0;
        stalled = 1'b0;
        for (int c = 0; c < 3 * p + 4; c++) begin
            if (stalled && n > 0)        tag = "R4";
            else if (d == 0)             tag = "R2";
            else if (n >= p)             tag = "R3";
            else if (ph == 0 && (p % 2)) tag = "R8";
            else if (ph == 0)            tag = "R5";
            else                         tag = "R6";
            chk(early, late, lvl(ph + 2 * n, p), lvl(ph + 2 * n + 1, p), tag);
            step_lfsr();
            adv = lfsr[0] | lfsr[1];
            @(posedge clk);
            stalled = !adv;
            if (adv) n++;
            @(negedge clk);
        end
        // R7: drop enable with a strobe present; reload must win
        en = 1'b0; adv = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(early, late, lvl(ph, p), lvl(ph + 1, p), "R7");
        adv = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state with period 1, phase 0
        #(CLK_PERIOD * 2 + 1);
        chk(early, late, 1'b0, 1'b1, "R1");
        period = 4'd4;
        #1;
        chk(early, late, 1'b0, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        period = 4'd1;
        @(negedge clk);
        chk(early, late, 1'b0, 1'b1, "R1");

        // R6: directed example, period 2, phase 1, advancing every cycle
        period = 4'd2; phase = 4'd1; en = 1'b0;
        @(posedge clk); @(negedge clk);
        en = 1'b1; adv = 1'b1;
        chk(early, late, 1'b0, 1'b1, "R6");
        @(posedge clk); @(negedge clk);
        chk(early, late, 1'b1, 1'b0, "R6");
        @(posedge clk); @(negedge clk);
        chk(early, late, 1'b0, 1'b1, "R6");

        // R3: period 1 toggles inside every cycle
        en = 1'b0; period = 4'd1; phase = 4'd0;
        @(posedge clk); @(negedge clk);
        en = 1'b1; adv = 1'b1;
        for (int c = 0; c < 4; c++) begin
            chk(early, late, 1'b0, 1'b1, "R3");
            @(posedge clk); @(negedge clk);
        end
        en = 1'b0; adv = 1'b0;

        // Sweep of every legal period and phase
        for (int d = 0; d < 16; d++) begin
            for (int ph = 0; ph < 16; ph++) begin
                if (ph < 2 * ((d == 0) ? 16 : d)) run_case(d, ph);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule